// File: doc/BRIEF.md
# Receive Self-Test Pattern Checker

This block sits behind the character decoder of a serial receive path and verifies a link carrying the repeating 511-character pseudo-random test pattern. The transmitter produces that pattern with a 9-bit maximal-length shift register. The block is enabled through an asynchronous, active-low test request. While the request is held, the block locks onto the start of the pattern and then compares every received character against a locally regenerated copy.

After the request is recognised, the checker is in a waiting phase. It ignores traffic until it sees the seed character, which is the first character of the pattern. From that point it is in a matching phase. Each valid character is compared with the next expected value. A wrong character raises a one-cycle error pulse and sends the checker back to waiting, so that it locks on again at the next seed. Each complete, error-free pass of 511 characters gives a one-cycle loop pulse.

While the test runs, the receive FIFO empty status presented to the host is forced to show empty, so the host does not read test traffic as data. A mode input selects whether the loop and empty status outputs are active high or active low.

Top module: `bist_rx_checker`

## Requirements
- R1: The level on `rx_test_n` passes through two clock-edge synchroniser stages. After a change of `rx_test_n`, test mode is recognised as on (low) or off (high) from the second rising edge onward, and not at the first edge.
- R2: While test mode is off, received characters have no effect. `err_o` stays low and `loop_o` stays at its inactive level.
- R3: After test mode turns on, the checker waits. Only a valid character equal to the seed 9'h1FF starts the matching phase. Any other character in the waiting phase is dropped without an error pulse.
- R4: The expected sequence starts at the seed, and each later value is {s[7:0], s[8]^s[4]} of the one before it. Only cycles with `char_valid_i` high advance the comparison. Idle cycles leave it unchanged.
- R5: In the matching phase, a valid character that differs from the expected value drives `err_o` high for exactly the one cycle after the clock edge that accepted it. The checker then returns to waiting.
- R6: Each run of 511 consecutive matching characters, counting the seed as the first, gives a one-cycle loop pulse in the cycle after the 511th character is accepted. Matching then continues into the next pass.
- R7: While test mode is on, `fifo_empty_o` shows empty whatever `fifo_empty_i` is. While it is off, `fifo_empty_o` follows `fifo_empty_i`. `fifo_empty_i` is high for empty.
- R8: With `flag_pol` = 1, `loop_o` and `fifo_empty_o` are active high. With `flag_pol` = 0, both are active low. `err_o` is always active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_test_n | input | 1 | Asynchronous active-low self-test request |
| flag_pol | input | 1 | Status polarity: 1 active high, 0 active low |
| fifo_empty_i | input | 1 | Receive FIFO empty status, high when empty |
| char_valid_i | input | 1 | Received character strobe |
| char_i | input | 9 | Decoded received character |
| err_o | output | 1 | One-cycle mismatch pulse |
| loop_o | output | 1 | One-cycle pass-complete pulse, polarity per `flag_pol` |
| fifo_empty_o | output | 1 | Empty status to the host, forced to empty during the test |

## Verification
The assertions assume that `rx_test_n` reaches the core only through the synchroniser. They also assume that `char_valid_i` and `char_i` are steady around the rising edge, and that `flag_pol` changes only while no pulse is expected. The stimulus drives every input on the falling edge and changes polarity only between test runs, with the request off. Corrupted characters are made by flipping one bit of the expected value, so they can never equal the value they replace. When the seed itself is corrupted, the flipped value cannot be mistaken for a later pattern character that happens to equal the seed.

// File: rtl/bist_rx_pkg.sv
// Shared types for the receive self-test checker.
// Assumes nothing beyond being compiled before the modules that import it.
package bist_rx_pkg;

    // Phase of the checker state machine
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_MATCH = 2'd2
    } chk_state_e;

endpackage

// File: rtl/bist_sync.sv
// Level synchroniser for the asynchronous active-low test request.
// Produces an active-high "test on" level after STAGES rising edges.
// Assumes the request is a slow level, not a pulse.
module bist_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic test_on
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the request level
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= req_n;
            end
        end else begin : g_multi
            // Shift the request level through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], req_n};
            end
        end
    endgenerate

    assign test_on = ~chain_q[STAGES-1];

endmodule

// File: rtl/bist_seq_gen.sv
// Expected-character generator: a Fibonacci shift register that is
// loaded with the successor of the seed and stepped once per accepted
// character. Assumes load and step are never raised together.
module bist_seq_gen #(
    parameter int          W    = 9,
    parameter int          TAP  = 5,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] exp_o
);

    logic [W-1:0] exp_q;

    // Next value of the pattern register
    function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
        return {s[W-2:0], s[W-1] ^ s[TAP-1]};
    endfunction

    // Hold, load after seed, or advance the expected value
    always_ff @(posedge clk) begin
        if (!rst_n)    exp_q <= SEED;
        else if (load) exp_q <= nxt(SEED);
        else if (step) exp_q <= nxt(exp_q);
    end

    assign exp_o = exp_q;

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(load && step)); // R4

endmodule

// File: rtl/bist_rx_fsm.sv
// Wait/match state machine. It compares each valid character with the
// expected value, counts matches per pass and raises one-cycle error and
// loop pulses. Assumes test_on is already synchronous to clk.
module bist_rx_fsm
    import bist_rx_pkg::*;
#(
    parameter int           W    = 9,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_on,
    input  logic         valid,
    input  logic [W-1:0] chr,
    input  logic [W-1:0] exp_chr,
    output logic         load,
    output logic         step,
    output logic         err_pulse,
    output logic         loop_pulse
);

    localparam int PERIOD = (1 << W) - 1;
    localparam int CNT_W  = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    chk_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             loop_q;
    logic             hit;

    assign hit  = valid && (chr == exp_chr);
    assign load = test_on && (state_q == ST_WAIT) && valid && (chr == SEED);
    assign step = test_on && (state_q == ST_MATCH) && hit;

    // Phase sequencing, pass counting and pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            loop_q  <= 1'b0;
        end else begin
            err_q  <= 1'b0;
            loop_q <= 1'b0;
            if (!test_on) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: state_q <= ST_WAIT;
                    ST_WAIT: begin
                        if (load) begin
                            state_q <= ST_MATCH;
                            cnt_q   <= CNT_W'(1);
                        end
                    end
                    ST_MATCH: begin
                        if (valid) begin
                            if (hit) begin
                                if (cnt_q == LAST) begin
                                    cnt_q  <= '0;
                                    loop_q <= 1'b1;
                                end else begin
                                    cnt_q <= cnt_q + 1'b1;
                                end
                            end else begin
                                err_q   <= 1'b1;
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign err_pulse  = err_q;
    assign loop_pulse = loop_q;

    AST_ERR_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) err_q |=> !err_q); // R5
    AST_ERR_TO_WAIT:    assert property (@(posedge clk) disable iff (!rst_n) err_q |-> (state_q == ST_WAIT)); // R5
    AST_LOOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) loop_q |=> !loop_q); // R6
    AST_CNT_RANGE:      assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST); // R6
    AST_QUIET_OFF:      assert property (@(posedge clk) disable iff (!rst_n) !test_on |=> (!err_q && !loop_q)); // R2
    AST_IDLE_WHEN_OFF:  assert property (@(posedge clk) disable iff (!rst_n) !test_on |=> (state_q == ST_IDLE)); // R2
    AST_WAIT_ON_ENTRY:  assert property (@(posedge clk) disable iff (!rst_n) (test_on && state_q == ST_IDLE) |=> (state_q == ST_WAIT || !test_on)); // R3

endmodule

// File: rtl/bist_flag_out.sv
// Status output stage: forces the FIFO empty status during the test and
// applies the selected polarity to the loop and empty outputs.
// Assumes flag_pol is quasi-static.
module bist_flag_out (
    input  logic test_on,
    input  logic flag_pol,
    input  logic fifo_empty_i,
    input  logic loop_pulse,
    output logic loop_o,
    output logic fifo_empty_o
);

    logic empty_int;

    // Forced-empty merge and polarity selection
    always_comb begin
        empty_int    = test_on | fifo_empty_i;
        loop_o       = flag_pol ? loop_pulse : ~loop_pulse;
        fifo_empty_o = flag_pol ? empty_int  : ~empty_int;
    end

endmodule

// File: rtl/bist_rx_checker.sv
// Top level of the receive self-test pattern checker: synchroniser,
// expected-sequence generator, wait/match machine and status output.
// Assumes decoded characters arrive synchronous to clk with a valid strobe.
module bist_rx_checker #(
    parameter int           W           = 9,
    parameter int           TAP         = 5,
    parameter logic [W-1:0] SEED        = '1,
    parameter int           SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_test_n,
    input  logic         flag_pol,
    input  logic         fifo_empty_i,
    input  logic         char_valid_i,
    input  logic [W-1:0] char_i,
    output logic         err_o,
    output logic         loop_o,
    output logic         fifo_empty_o
);

    logic         test_on;
    logic         load;
    logic         step;
    logic         loop_pulse;
    logic [W-1:0] exp_chr;

    bist_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (rx_test_n),
        .test_on (test_on)
    );

    bist_seq_gen #(.W(W), .TAP(TAP), .SEED(SEED)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .exp_o (exp_chr)
    );

    bist_rx_fsm #(.W(W), .SEED(SEED)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_on    (test_on),
        .valid      (char_valid_i),
        .chr        (char_i),
        .exp_chr    (exp_chr),
        .load       (load),
        .step       (step),
        .err_pulse  (err_o),
        .loop_pulse (loop_pulse)
    );

    bist_flag_out u_out (
        .test_on      (test_on),
        .flag_pol     (flag_pol),
        .fifo_empty_i (fifo_empty_i),
        .loop_pulse   (loop_pulse),
        .loop_o       (loop_o),
        .fifo_empty_o (fifo_empty_o)
    );

    AST_EMPTY_FORCED: assert property (@(posedge clk) disable iff (!rst_n) (test_on && flag_pol) |-> fifo_empty_o); // R7

endmodule

// File: tb/bist_rx_checker_bench.sv
module bist_rx_checker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_test_n = 1'b1;
    logic       flag_pol = 1'b1;
    logic       fifo_empty_i = 1'b1;
    logic       char_valid_i = 1'b0;
    logic [8:0] char_i = '0;
    logic       err_o, loop_o, fifo_empty_o;

    int checks = 0;
    int errors = 0;
    int n_loop = 0;
    int n_err  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bist_rx_checker u_bist_rx_checker (
        .clk(clk), .rst_n(rst_n), .rx_test_n(rx_test_n), .flag_pol(flag_pol),
        .fifo_empty_i(fifo_empty_i), .char_valid_i(char_valid_i), .char_i(char_i),
        .err_o(err_o), .loop_o(loop_o), .fifo_empty_o(fifo_empty_o)
    );

    // Row: polarity, length, corrupt index (2047 = none), loops, errors
    typedef struct packed {
        logic        pol;
        logic [10:0] len;
        logic [10:0] cidx;
        logic [2:0]  loops;
        logic [2:0]  errs;
    } row_t;

    localparam int NROWS = 5;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1, 11'd511,  11'd2047, 3'd1, 3'd0},   // R6 single pass
        '{1'b0, 11'd1022, 11'd2047, 3'd2, 3'd0},   // R6 R8 two passes, active low
        '{1'b1, 11'd1022, 11'd100,  3'd1, 3'd1},   // R5 mid-pass error then relock
        '{1'b1, 11'd1022, 11'd0,    3'd1, 3'd0},   // R3 corrupted seed ignored
        '{1'b0, 11'd1022, 11'd510,  3'd1, 3'd1}    // R5 error on last character
    };

    function automatic logic [8:0] nx(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle on the falling edge and record pulses after the rise
    task automatic cyc(input logic [8:0] c, input logic v);
        @(negedge clk);
        char_i = c;
        char_valid_i = v;
        @(posedge clk);
        #1;
        if (err_o) n_err++;
        if (loop_o == flag_pol) n_loop++;
    endtask

    // Send len pattern characters from the seed, optional corruption and gaps
    task automatic send(input int len, input int cidx);
        logic [8:0] s = 9'h1FF;
        for (int i = 0; i < len; i++) begin
            cyc((i == cidx) ? (s ^ 9'h001) : s, 1'b1);
            if (i % 7 == 3) cyc(9'h000, 1'b0);  // R4 idle cycle must not advance
            s = nx(s);
        end
        cyc(9'h000, 1'b0);
    endtask

    task automatic set_test(input logic on);
        @(negedge clk);
        rx_test_n = ~on;
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // Reset state and pass-through
        chk(err_o == 1'b0, "R2 reset err", err_o, 0);
        chk(loop_o == 1'b0, "R8 reset loop high-active idle", loop_o, 0);
        chk(fifo_empty_o == 1'b1, "R7 pass-through empty", fifo_empty_o, 1);
        @(negedge clk); fifo_empty_i = 1'b0; #1;
        chk(fifo_empty_o == 1'b0, "R7 pass-through not empty", fifo_empty_o, 0);
        flag_pol = 1'b0; #1;
        chk(fifo_empty_o == 1'b1, "R8 active-low not empty", fifo_empty_o, 1);
        chk(loop_o == 1'b1, "R8 active-low loop idle", loop_o, 1);
        flag_pol = 1'b1;

        // R1 synchroniser latency
        @(negedge clk); rx_test_n = 1'b0;
        @(posedge clk); #1;
        chk(fifo_empty_o == 1'b0, "R1 not on after one edge", fifo_empty_o, 0);
        @(posedge clk); #1;
        chk(fifo_empty_o == 1'b1, "R1 on after two edges", fifo_empty_o, 1);
        @(negedge clk); rx_test_n = 1'b1;
        @(posedge clk); #1;
        chk(fifo_empty_o == 1'b1, "R1 still on after one edge", fifo_empty_o, 1);
        @(posedge clk); #1;
        chk(fifo_empty_o == 1'b0, "R1 off after two edges", fifo_empty_o, 0);

        // R2 traffic ignored while off
        n_err = 0; n_loop = 0;
        send(511, 2047);
        chk(n_loop == 0, "R2 no loop while off", n_loop, 0);
        chk(n_err == 0, "R2 no error while off", n_err, 0);

        // Table-driven runs
        for (int r = 0; r < NROWS; r++) begin
            set_test(1'b0);
            flag_pol = ROWS[r].pol;
            set_test(1'b1);
            chk(fifo_empty_o == ROWS[r].pol, "R7 forced empty in test", fifo_empty_o, ROWS[r].pol);
            n_err = 0; n_loop = 0;
            send(ROWS[r].len, ROWS[r].cidx);
            chk(n_loop == ROWS[r].loops, "R6 loop count", n_loop, ROWS[r].loops);
            chk(n_err == ROWS[r].errs, "R5 error count", n_err, ROWS[r].errs);
        end

        // R3 traffic before the seed is ignored
        set_test(1'b0);
        flag_pol = 1'b1;
        set_test(1'b1);
        n_err = 0; n_loop = 0;
        for (int i = 0; i < 20; i++) cyc(9'(i * 3), 1'b1);
        chk(n_err == 0, "R3 no error in wait phase", n_err, 0);
        send(511, 2047);
        chk(n_loop == 1, "R3 lock after seed", n_loop, 1);

        // R1 R6 interrupted pass then clean pass
        set_test(1'b0);
        set_test(1'b1);
        n_err = 0; n_loop = 0;
        send(200, 2047);
        set_test(1'b0);
        set_test(1'b1);
        send(511, 2047);
        chk(n_loop == 1, "R6 clean pass after restart", n_loop, 1);
        chk(n_err == 0, "R4 no error after restart", n_err, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule